// File: doc/BRIEF.md
# Program Flow Target Unit

This block works out where an 8051-class core goes next after an unconditional control transfer. A fetch stage hands it an opcode, up to two operand bytes and the address of that opcode. The execute side provides the accumulator and the 16-bit data pointer. For long and absolute jumps, long and absolute calls, the indirect jump through accumulator plus data pointer, and the two return forms, the block produces a new program counter together with a one-cycle valid strobe.

Calls save their return address in an internal byte-wide stack that is addressed by an 8-bit stack pointer. The pointer is exposed on a port. Returns read that address back from the stack. A return from interrupt also sends a one-cycle completion strobe to the interrupt controller.

Jumps finish in a single cycle. Calls need two cycles, one for each byte written to the stack. Returns need three cycles because the stack memory has a synchronous read port. While a multi-cycle transfer is in progress, `busy` is high and new instructions are not accepted.

Top module: `flow_ctrl_unit`

## Requirements
- R1: Opcode 0x02 (long jump) loads `pc_out` with {op1, op2}, where op1 is the high byte. `pc_valid` pulses one cycle after the instruction is accepted.
- R2: An opcode of the form bbb00001 is an absolute jump. Its 11-bit target has bits 10..8 equal to opcode bits 7..5 and bits 7..0 equal to op1. `pc_valid` pulses one cycle after acceptance.
- R3: For both absolute forms, bits 15..11 of the new PC come from `pc_in + 2`, so the target lies in the 2K block of the following instruction, even when that block differs from the opcode's own block.
- R4: Opcode 0x73 (indirect jump) loads `pc_out` with (dptr + acc) mod 65536, one cycle after acceptance.
- R5: Opcode 0x12 (long call) jumps to {op1, op2}. It pushes the return address `pc_in + 3`: first the low byte at sp+1, then the high byte at sp+2. The stack pointer ends up 2 higher, and `pc_valid` pulses two cycles after acceptance.
- R6: An opcode of the form bbb10001 is an absolute call. Its target is formed as in R2 and R3, it pushes the return address `pc_in + 2`, and its stack pointer and timing match R5.
- R7: Opcode 0x22 (return) pops the high byte and then the low byte, decrementing the stack pointer after each read. It loads `pc_out` with the popped address three cycles after acceptance. Nested calls return in last-in first-out order.
- R8: Opcode 0x32 (return from interrupt) behaves exactly as R7. In addition, `irq_done` is high for exactly the one cycle in which its `pc_valid` is high. `irq_done` is never raised by any other opcode.
- R9: Any other opcode is ignored: no `pc_valid` pulse follows and `sp_out` does not change.
- R10: The stack pointer wraps modulo 256 in both directions.
- R11: `busy` is high from acceptance of a call or return until its `pc_valid` cycle. While `busy` is high, `instr_valid` is ignored.
- R12: After synchronous reset, `pc_out` is 0, `pc_valid`, `irq_done` and `busy` are low, and `sp_out` equals the SP_RESET parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction bytes are valid this cycle |
| opcode | input | 8 | Opcode byte |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte |
| pc_in | input | 16 | Address of the opcode byte |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| busy | output | 1 | Multi-cycle transfer in progress |
| pc_valid | output | 1 | One-cycle strobe: `pc_out` holds a new PC |
| pc_out | output | 16 | Next program counter |
| irq_done | output | 1 | One-cycle strobe on completion of a return from interrupt |
| sp_out | output | 8 | Current stack pointer |

## Verification
The bench instantiates the block with SP_RESET set to 0xFE and leaves the other parameters at their defaults. With that reset value, the very first call pushes its two bytes across the 0xFF to 0x00 boundary, and the matching return unwinds back across the same boundary. Both directions of the stack pointer wrap are therefore exercised without first filling the stack. The 16-bit PC width allows the absolute-form tests to place an opcode two bytes below a 2K boundary, and lets the indirect-jump sum carry past 0xFFFF.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam logic [7:0] OPC_LJMP  = 8'h02;
  localparam logic [7:0] OPC_LCALL = 8'h12;
  localparam logic [7:0] OPC_JMPI  = 8'h73;
  localparam logic [7:0] OPC_RET   = 8'h22;
  localparam logic [7:0] OPC_RETI  = 8'h32;
  localparam logic [4:0] ABS_JMP_LO  = 5'b00001;
  localparam logic [4:0] ABS_CALL_LO = 5'b10001;

  typedef enum logic [2:0] {K_NONE, K_JUMP, K_CALL, K_RET, K_RETI} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_PUSH_HI, S_POP_LO, S_POP_DONE} state_e;
endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int ABS_W = 11
) (
  input  logic [7:0]      opcode,
  input  logic [7:0]      op1,
  input  logic [7:0]      op2,
  input  logic [PC_W-1:0] pc,
  input  logic [7:0]      acc,
  input  logic [PC_W-1:0] dptr,
  output kind_e           kind,
  output logic [PC_W-1:0] target,
  output logic [PC_W-1:0] ret_addr
);
  localparam int OPB     = 8;
  localparam int HI_BITS = ABS_W - OPB;

  logic [PC_W-1:0] next2, next3, abs_tgt, ind_tgt, long_tgt;
  logic [OPB-HI_BITS-1:0] low_sel;

  assign next2    = pc + PC_W'(2);
  assign next3    = pc + PC_W'(3);
  assign abs_tgt  = {next2[PC_W-1:ABS_W], opcode[OPB-1 -: HI_BITS], op1};
  assign ind_tgt  = dptr + PC_W'(acc);
  assign long_tgt = PC_W'({op1, op2});
  assign low_sel  = opcode[OPB-HI_BITS-1:0];

  always_comb begin
    kind     = K_NONE;
    target   = '0;
    ret_addr = next3;
    if (opcode == OPC_LJMP) begin
      kind   = K_JUMP;
      target = long_tgt;
    end else if (opcode == OPC_LCALL) begin
      kind   = K_CALL;
      target = long_tgt;
    end else if (opcode == OPC_JMPI) begin
      kind   = K_JUMP;
      target = ind_tgt;
    end else if (opcode == OPC_RET) begin
      kind = K_RET;
    end else if (opcode == OPC_RETI) begin
      kind = K_RETI;
    end else if (low_sel == ABS_JMP_LO) begin
      kind   = K_JUMP;
      target = abs_tgt;
    end else if (low_sel == ABS_CALL_LO) begin
      kind     = K_CALL;
      target   = abs_tgt;
      ret_addr = next2;
    end
  end
endmodule

// File: rtl/flow_stack_ram.sv
module flow_stack_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
  import flow_pkg::*;
#(
  parameter int               PC_W     = 16,
  parameter int               SP_W     = 8,
  parameter logic [SP_W-1:0]  SP_RESET = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [7:0]      opcode,
  input  logic [7:0]      op1,
  input  logic [7:0]      op2,
  input  logic [PC_W-1:0] pc_in,
  input  logic [7:0]      acc,
  input  logic [PC_W-1:0] dptr,
  output logic            busy,
  output logic            pc_valid,
  output logic [PC_W-1:0] pc_out,
  output logic            irq_done,
  output logic [SP_W-1:0] sp_out
);
  localparam int HALF = PC_W / 2;

  kind_e           kind;
  logic [PC_W-1:0] target, ret_addr;

  state_e          state_q;
  logic [SP_W-1:0] sp_q;
  logic [HALF-1:0] hi_q;
  logic [PC_W-1:0] tgt_q, pc_q;
  logic            reti_q, valid_q, done_q;

  logic            ram_we;
  logic [SP_W-1:0] ram_waddr;
  logic [HALF-1:0] ram_wdata, ram_rdata;

  flow_decode #(.PC_W(PC_W)) u_dec (
    .opcode  (opcode),
    .op1     (op1),
    .op2     (op2),
    .pc      (pc_in),
    .acc     (acc),
    .dptr    (dptr),
    .kind    (kind),
    .target  (target),
    .ret_addr(ret_addr)
  );

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = sp_q + SP_W'(1);
    ram_wdata = ret_addr[HALF-1:0];
    if (state_q == S_IDLE && instr_valid && kind == K_CALL) begin
      ram_we = 1'b1;
    end else if (state_q == S_PUSH_HI) begin
      ram_we    = 1'b1;
      ram_wdata = hi_q;
    end
  end

  flow_stack_ram #(.AW(SP_W), .DW(HALF)) u_stack (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(sp_q),
    .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      sp_q    <= SP_RESET;
      hi_q    <= '0;
      tgt_q   <= '0;
      pc_q    <= '0;
      reti_q  <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (instr_valid) begin
            case (kind)
              K_JUMP: begin
                pc_q    <= target;
                valid_q <= 1'b1;
              end
              K_CALL: begin
                sp_q    <= sp_q + SP_W'(1);
                hi_q    <= ret_addr[PC_W-1:HALF];
                tgt_q   <= target;
                state_q <= S_PUSH_HI;
              end
              K_RET, K_RETI: begin
                sp_q    <= sp_q - SP_W'(1);
                reti_q  <= (kind == K_RETI);
                state_q <= S_POP_LO;
              end
              default: ;
            endcase
          end
        end
        S_PUSH_HI: begin
          sp_q    <= sp_q + SP_W'(1);
          pc_q    <= tgt_q;
          valid_q <= 1'b1;
          state_q <= S_IDLE;
        end
        S_POP_LO: begin
          hi_q    <= ram_rdata;
          sp_q    <= sp_q - SP_W'(1);
          state_q <= S_POP_DONE;
        end
        S_POP_DONE: begin
          pc_q    <= {hi_q, ram_rdata};
          valid_q <= 1'b1;
          done_q  <= reti_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign pc_valid = valid_q;
  assign pc_out   = pc_q;
  assign irq_done = done_q;
  assign sp_out   = sp_q;
endmodule

// File: rtl/flow_ctrl_chk.sv
module flow_ctrl_chk #(
  parameter int PC_W = 16,
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            instr_valid,
  input logic [7:0]      opcode,
  input logic [7:0]      op1,
  input logic [7:0]      op2,
  input logic [PC_W-1:0] pc_in,
  input logic [7:0]      acc,
  input logic [PC_W-1:0] dptr,
  input logic            busy,
  input logic            pc_valid,
  input logic [PC_W-1:0] pc_out,
  input logic            irq_done,
  input logic [SP_W-1:0] sp_out
);
  logic            acc_ok, is_ljmp, is_ajmp, is_jmpi, is_call, is_ret, is_reti, is_none;
  logic [PC_W-1:0] base_c, sum_c;
  logic [SP_W-1:0] sp_p2, sp_m2;

  assign acc_ok  = instr_valid && !busy;
  assign is_ljmp = acc_ok && opcode == 8'h02;
  assign is_ajmp = acc_ok && opcode[4:0] == 5'b00001;
  assign is_jmpi = acc_ok && opcode == 8'h73;
  assign is_call = acc_ok && (opcode == 8'h12 || opcode[4:0] == 5'b10001);
  assign is_ret  = acc_ok && (opcode == 8'h22 || opcode == 8'h32);
  assign is_reti = acc_ok && opcode == 8'h32;
  assign is_none = acc_ok && !(is_ljmp || is_ajmp || is_jmpi || is_call || is_ret);
  assign base_c  = pc_in + PC_W'(2);
  assign sum_c   = dptr + PC_W'(acc);
  assign sp_p2   = sp_out + SP_W'(2);
  assign sp_m2   = sp_out - SP_W'(2);

  // R1
  ljmp_target_chk: assert property (@(posedge clk) disable iff (rst)
    is_ljmp |=> pc_valid && pc_out == PC_W'({$past(op1), $past(op2)}));

  // R3
  ajmp_block_chk: assert property (@(posedge clk) disable iff (rst)
    is_ajmp |=> pc_valid && pc_out[PC_W-1:11] == $past(base_c[PC_W-1:11]));

  // R4
  jmpi_sum_chk: assert property (@(posedge clk) disable iff (rst)
    is_jmpi |=> pc_valid && pc_out == $past(sum_c));

  // R5
  call_sp_chk: assert property (@(posedge clk) disable iff (rst)
    is_call |=> ##1 (pc_valid && sp_out == $past(sp_p2, 2)));

  // R7
  ret_sp_chk: assert property (@(posedge clk) disable iff (rst)
    is_ret |=> ##2 (pc_valid && sp_out == $past(sp_m2, 3)));

  // R8
  reti_done_chk: assert property (@(posedge clk) disable iff (rst)
    is_reti |=> ##2 irq_done);

  // R8
  ret_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (is_ret && !is_reti) |=> ##2 !irq_done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> pc_valid);

  // R9
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    is_none |=> !pc_valid && $stable(sp_out));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !pc_valid) |=> !pc_valid || !busy);
endmodule

bind flow_ctrl_unit flow_ctrl_chk #(.PC_W(PC_W), .SP_W(SP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .instr_valid(instr_valid),
  .opcode     (opcode),
  .op1        (op1),
  .op2        (op2),
  .pc_in      (pc_in),
  .acc        (acc),
  .dptr       (dptr),
  .busy       (busy),
  .pc_valid   (pc_valid),
  .pc_out     (pc_out),
  .irq_done   (irq_done),
  .sp_out     (sp_out)
);

// File: tb/tb_flow_ctrl_unit.sv
module tb_flow_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [7:0]  opcode = '0, op1 = '0, op2 = '0, acc = '0;
  logic [15:0] pc_in = '0, dptr = '0;
  logic        busy, pc_valid, irq_done;
  logic [15:0] pc_out;
  logic [7:0]  sp_out;

  always #5 clk = ~clk;

  flow_ctrl_unit #(.PC_W(16), .SP_W(8), .SP_RESET(8'hFE)) dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
    .op1(op1), .op2(op2), .pc_in(pc_in), .acc(acc), .dptr(dptr),
    .busy(busy), .pc_valid(pc_valid), .pc_out(pc_out),
    .irq_done(irq_done), .sp_out(sp_out)
  );

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  sp;
    logic        irq;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   tests = 0, fails = 0, cyc = 0, seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (pc_valid) begin
        seen++;
        if (q.size() == 0) begin
          check("R9 unexpected pc_valid", 32'(pc_out), 32'hFFFF_FFFF);
        end else begin
          e = q.pop_front();
          check({e.tag, " pc"}, 32'(pc_out), 32'(e.pc));
          check({e.tag, " sp"}, 32'(sp_out), 32'(e.sp));
          check({e.tag, " irq_done (R8)"}, 32'(irq_done), 32'(e.irq));
          check({e.tag, " latency cycle"}, 32'(cyc), 32'(e.due));
        end
      end else if (irq_done) begin
        check("R8 irq_done without pc_valid", 32'(irq_done), 32'h0);
      end
    end
  end

  // driver: called at a negedge, returns at a negedge
  task automatic issue(input logic [7:0] opc, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [15:0] pc, input logic [7:0] a, input logic [15:0] dp,
                       input int lat, input int hold, input logic expect_out,
                       input logic [15:0] epc, input logic [7:0] esp, input logic eirq,
                       input string tag);
    exp_t it;
    opcode = opc; op1 = b1; op2 = b2; pc_in = pc; acc = a; dptr = dp;
    instr_valid = 1'b1;
    if (expect_out) begin
      it.pc = epc; it.sp = esp; it.irq = eirq; it.due = cyc + lat; it.tag = tag;
      q.push_back(it);
    end
    for (int i = 0; i < hold; i++) @(negedge clk);
    instr_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset values
    check("R12 pc_out", 32'(pc_out), 32'h0);
    check("R12 pc_valid", 32'(pc_valid), 32'h0);
    check("R12 irq_done", 32'(irq_done), 32'h0);
    check("R12 busy", 32'(busy), 32'h0);
    check("R12 sp_out", 32'(sp_out), 32'hFE);
    rst = 1'b0;
    @(negedge clk);

    // R1 long jump
    issue(8'h02, 8'h12, 8'h34, 16'h0500, 8'h00, 16'h0000, 1, 1, 1'b1, 16'h1234, 8'hFE, 1'b0, "R1 ljmp");
    // R2 R3 absolute jumps
    issue(8'hA1, 8'h5C, 8'h00, 16'h37FE, 8'h00, 16'h0000, 1, 1, 1'b1, 16'h3D5C, 8'hFE, 1'b0, "R2 ajmp");
    issue(8'h01, 8'h10, 8'h00, 16'h07FE, 8'h00, 16'h0000, 1, 1, 1'b1, 16'h0810, 8'hFE, 1'b0, "R3 ajmp block crossing");
    issue(8'hE1, 8'hFF, 8'h00, 16'h1234, 8'h00, 16'h0000, 1, 1, 1'b1, 16'h17FF, 8'hFE, 1'b0, "R2 ajmp top of block");
    // R4 indirect jump
    issue(8'h73, 8'h00, 8'h00, 16'h0040, 8'h20, 16'hFFF0, 1, 1, 1'b1, 16'h0010, 8'hFE, 1'b0, "R4 jmpi wrap");
    issue(8'h73, 8'h00, 8'h00, 16'h0040, 8'h04, 16'h1000, 1, 1, 1'b1, 16'h1004, 8'hFE, 1'b0, "R4 jmpi");
    // R5 R10 R11 long call, held valid while busy, sp wraps FE->00
    issue(8'h12, 8'hAB, 8'hCD, 16'h0100, 8'h00, 16'h0000, 2, 2, 1'b1, 16'hABCD, 8'h00, 1'b0, "R5 R10 R11 lcall");
    // R6 absolute call
    issue(8'h71, 8'h22, 8'h00, 16'hABD0, 8'h00, 16'h0000, 2, 1, 1'b1, 16'hAB22, 8'h02, 1'b0, "R6 acall");
    // R7 return to acall site
    issue(8'h22, 8'h00, 8'h00, 16'hAB22, 8'h00, 16'h0000, 3, 1, 1'b1, 16'hABD2, 8'h00, 1'b0, "R7 ret");
    // R8 R10 return from interrupt to lcall site, sp wraps 00->FE
    issue(8'h32, 8'h00, 8'h00, 16'hABD2, 8'h00, 16'h0000, 3, 1, 1'b1, 16'h0103, 8'hFE, 1'b1, "R8 R10 reti");
    // R9 ignored opcodes
    issue(8'h00, 8'h12, 8'h34, 16'h0200, 8'h00, 16'h0000, 0, 1, 1'b0, 16'h0, 8'h0, 1'b0, "R9");
    issue(8'hFF, 8'h12, 8'h34, 16'h0200, 8'h00, 16'h0000, 0, 1, 1'b0, 16'h0, 8'h0, 1'b0, "R9");
    repeat (4) @(negedge clk);
    check("R9 sp unchanged", 32'(sp_out), 32'hFE);
    check("R9 pc_out held", 32'(pc_out), 32'h0103);
    check("R9 results seen", 32'(seen), 32'd10);
    check("R11 queue drained", 32'(q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule